// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block is the read-side output multiplexer of a byte-wide non-volatile memory with a self-timed program cycle. It watches the chip enable, output enable and write enable pins and decides, on every clock, whether the data bus is driven and with what. When no program cycle is running, a read returns the byte the array presents for the latched address. While the write controller reports that a program cycle is in progress, the array is not readable. The block then answers every read with a status byte that lets the host software tell when programming has finished.

The status byte has two signals in it. The most significant bit is a polling bit: when the read address equals the last address written, it carries the complement of bit 7 of the last byte written. Bit 6 is a toggle bit. It changes value once for every new read access made while the cycle runs. The remaining bits are held at zero. The write controller supplies the busy flag, a one-cycle start pulse, and the last address and byte it loaded.

The control pins are sampled into registers on each clock. A three-state machine then picks the bus content: `ST_IDLE` (bus released), `ST_ARRAY` (true data) and `ST_STATUS` (status encoding). Its transitions are:
- `ST_IDLE`→`ST_STATUS` on a read request while busy, which advances the toggle.
- `ST_IDLE`→`ST_ARRAY` on a read request while idle.
- `ST_ARRAY`→`ST_STATUS` when busy rises mid-read.
- `ST_STATUS`→`ST_ARRAY` when busy falls mid-read.
- Either driving state → `ST_IDLE` when the read request ends.

Top module: `wstat_readmux`

## Requirements
- R1: While reset is asserted and after its release with no read request, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: The bus is driven (`dq_oe`=1) only when `we_n` is 1 and both `ce_n` and `oe_n` are 0. Otherwise `dq_oe` is 0 and `dq_out` is zero. A pin change shows at the outputs after the second rising clock edge.
- R3: With `prog_busy` low, a read drives `dq_out` equal to `array_rdata`.
- R4: With `prog_busy` high and the read address equal to `last_addr`, `dq_out[7]` is the complement of `last_data[7]`.
- R5: With `prog_busy` high and the read address different from `last_addr`, `dq_out[7]` is 0.
- R6: With `prog_busy` high, `dq_out[6]` shows the toggle bit. The toggle inverts at the start of each new read access (read request rising while busy). The first such read after a start pulse returns 1, then 0, then 1, and so on. It does not change within one access.
- R7: With `prog_busy` high, `dq_out[5:0]` is zero during a read.
- R8: A one-cycle `prog_start` pulse clears the toggle to 0 and takes priority over an advance in the same cycle.
- R9: When `prog_busy` falls during an ongoing read, the bus switches to the true `array_rdata` without ending the access. Later reads return true data with no toggling.
- R10: When `prog_busy` rises during an ongoing array read, the bus switches to the status byte without advancing the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Read address from the pins |
| array_rdata | input | 8 | Byte read from the array at the latched address |
| prog_busy | input | 1 | High while the self-timed program cycle runs |
| prog_start | input | 1 | One-cycle pulse when a program cycle begins |
| last_addr | input | 15 | Address of the last byte loaded by the write controller |
| last_data | input | 8 | Value of the last byte loaded |
| dq_out | output | 8 | Data driven onto the bus |
| dq_oe | output | 1 | Three-state enable for the data bus |

## Verification
The bench first reads the last-written address with a byte whose bit 7 is 0, so a missing inversion shows up as a 0 instead of a 1. It then reads another address in the same cycle, which catches a design that polls every address. Back-to-back accesses confirm that bit 6 alternates, and that a design advancing on every clock or never advancing would produce the wrong sequence. Busy is raised inside an open array read to check that a switch of state mid-access does not count as a new read. Busy is also dropped mid-read to check that true data returns at once. A second start pulse, given while the toggle holds 1, exposes a missing clear.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARRAY  = 2'd1,
        ST_STATUS = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wstat_sample.sv
// Registers the asynchronous control pins and read address once per clock,
// forms the read request and the last-address match.
module wstat_sample #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              rd_req,
    output logic              hit
);
    logic              ce_q, oe_q, we_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            oe_q   <= 1'b1;
            we_q   <= 1'b1;
            addr_q <= '0;
        end else begin
            ce_q   <= ce_n;
            oe_q   <= oe_n;
            we_q   <= we_n;
            addr_q <= addr;
        end
    end

    assign rd_req = ~ce_q & ~oe_q & we_q;
    assign hit    = (addr_q == last_addr);
endmodule

// File: rtl/wstat_fsm.sv
// Read-path state machine: state register plus next-state logic.
module wstat_fsm
    import wstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_req,
    input  logic      busy,
    output rd_state_e state,
    output logic      advance
);
    rd_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        advance = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rd_req) begin
                    if (busy) begin
                        nxt     = ST_STATUS;
                        advance = 1'b1;
                    end else begin
                        nxt = ST_ARRAY;
                    end
                end
            end
            ST_ARRAY: begin
                if (!rd_req)   nxt = ST_IDLE;
                else if (busy) nxt = ST_STATUS;
            end
            ST_STATUS: begin
                if (!rd_req)    nxt = ST_IDLE;
                else if (!busy) nxt = ST_ARRAY;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wstat_toggle.sv
// Toggle flop: cleared by a program start, inverted once per new status read.
module wstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tog
);
    always_ff @(posedge clk) begin
        if (!rst_n)       tog <= 1'b0;
        else if (clear)   tog <= 1'b0;
        else if (advance) tog <= ~tog;
    end
endmodule

// File: rtl/wstat_encode.sv
// Output process: selects released bus, array data or status encoding.
module wstat_encode
    import wstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rd_state_e         state,
    input  logic              tog,
    input  logic              hit,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    always_comb begin
        dq_oe  = 1'b0;
        dq_out = '0;
        unique case (state)
            ST_IDLE: begin
                dq_oe = 1'b0;
            end
            ST_ARRAY: begin
                dq_oe  = 1'b1;
                dq_out = array_rdata;
            end
            ST_STATUS: begin
                dq_oe            = 1'b1;
                dq_out[TOG_BIT]  = tog;
                dq_out[POLL_BIT] = hit & ~last_msb;
            end
            default: dq_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/wstat_readmux.sv
module wstat_readmux
    import wstat_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              prog_busy,
    input  logic              prog_start,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic      rd_req, hit, advance, tog;
    rd_state_e state;

    wstat_sample #(.ADDR_W(ADDR_W)) u_sample (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .last_addr(last_addr), .rd_req(rd_req), .hit(hit)
    );

    wstat_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .busy(prog_busy),
        .state(state), .advance(advance)
    );

    wstat_toggle u_toggle (
        .clk(clk), .rst_n(rst_n), .clear(prog_start), .advance(advance),
        .tog(tog)
    );

    wstat_encode #(.DATA_W(DATA_W)) u_encode (
        .state(state), .tog(tog), .hit(hit), .last_msb(last_data[DATA_W-1]),
        .array_rdata(array_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/wstat_readmux_chk.sv
module wstat_readmux_chk
    import wstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              prog_start,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input rd_state_e         state,
    input logic              tog,
    input logic              hit
);
    logic pin_rd;
    assign pin_rd = ~ce_n & ~oe_n & we_n;

    // R2
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(pin_rd, 2));

    // R1
    released_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

    // R3
    array_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARRAY) |-> (dq_oe && dq_out == array_rdata));

    // R4
    poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STATUS && hit) |-> (dq_out[DATA_W-1] == ~last_data[DATA_W-1]));

    // R6
    toggle_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STATUS && $past(state) == ST_STATUS && !$past(prog_start))
            |-> $stable(dq_out[DATA_W-2]));

    // R7
    status_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STATUS) |-> (dq_out[DATA_W-3:0] == '0));

    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !tog);
endmodule

bind wstat_readmux wstat_readmux_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .prog_start(prog_start), .last_data(last_data), .array_rdata(array_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .state(state), .tog(tog), .hit(hit)
);

// File: tb/tb_wstat_readmux.sv
module tb_wstat_readmux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  array_rdata;
    logic        prog_busy = 1'b0, prog_start = 1'b0;
    logic [14:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    logic m_tog = 1'b0;
    bit   done = 1'b0;

    typedef struct {
        logic       oe;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    assign array_rdata = addr[7:0] ^ 8'h5A;

    wstat_readmux dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .array_rdata(array_rdata), .prog_busy(prog_busy),
        .prog_start(prog_start), .last_addr(last_addr), .last_data(last_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (dq_oe !== e.oe || dq_out !== e.data) begin
                    errors++;
                    $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                             e.tag, dq_oe, dq_out, e.oe, e.data);
                end
            end
        end
    end

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_bus(input logic oe, input logic [7:0] data, input string tag);
        exp_t e;
        e.oe = oe; e.data = data; e.tag = tag;
        sb.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] status_byte(input logic [14:0] a);
        return {(a == last_addr) ? ~last_data[7] : 1'b0, m_tog, 6'b0};
    endfunction

    task automatic open_read(input logic [14:0] a);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        if (prog_busy) m_tog = ~m_tog;
        settle();
    endtask

    task automatic close_read();
        oe_n = 1'b1; ce_n = 1'b1;
        settle();
    endtask

    task automatic start_prog(input logic [14:0] a, input logic [7:0] d);
        last_addr = a; last_data = d;
        prog_start = 1'b1; prog_busy = 1'b1; m_tog = 1'b0;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        expect_bus(1'b0, 8'h00, "R1 in reset");
        rst_n = 1'b1;
        settle();
        expect_bus(1'b0, 8'h00, "R1 after reset");

        // R3: plain reads with no program cycle
        open_read(15'h0011);
        expect_bus(1'b1, 8'h11 ^ 8'h5A, "R3 read 0011");
        addr = 15'h00F0; settle();
        expect_bus(1'b1, 8'hF0 ^ 8'h5A, "R3 read 00F0");
        close_read();
        expect_bus(1'b0, 8'h00, "R2 released after read");

        // R2: gating combinations
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; settle();
        expect_bus(1'b0, 8'h00, "R2 write enable low");
        we_n = 1'b1; ce_n = 1'b1; settle();
        expect_bus(1'b0, 8'h00, "R2 chip disabled");
        ce_n = 1'b0; oe_n = 1'b1; settle();
        expect_bus(1'b0, 8'h00, "R2 output disabled");
        close_read();

        // R4/R6/R7: status reads with bit 7 of last byte = 0
        start_prog(15'h1234, 8'h35);
        open_read(15'h1234);
        expect_bus(1'b1, status_byte(15'h1234), "R4 poll first read");
        repeat (4) @(negedge clk);
        expect_bus(1'b1, status_byte(15'h1234), "R6 steady within access");
        close_read();
        open_read(15'h1234);
        expect_bus(1'b1, status_byte(15'h1234), "R6 second read toggles");
        close_read();
        // R5: other address
        open_read(15'h0040);
        expect_bus(1'b1, status_byte(15'h0040), "R5 other address");
        close_read();

        // R8: clear while toggle is 1
        start_prog(15'h0777, 8'hC3);
        open_read(15'h0777);
        expect_bus(1'b1, status_byte(15'h0777), "R8 cleared toggle then advanced");
        close_read();
        open_read(15'h0777);
        expect_bus(1'b1, status_byte(15'h0777), "R7 bits zero, toggle 0");

        // R9: busy falls mid-read
        prog_busy = 1'b0; settle();
        expect_bus(1'b1, 8'h77 ^ 8'h5A, "R9 true data mid-read");
        close_read();
        open_read(15'h0777);
        expect_bus(1'b1, 8'h77 ^ 8'h5A, "R9 later read true data");

        // R10: busy rises during an array read, toggle not advanced
        start_prog(15'h0777, 8'h12);
        settle();
        expect_bus(1'b1, status_byte(15'h0777), "R10 switch without advance");
        close_read();
        prog_busy = 1'b0;
        settle();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule